// File: doc/BRIEF.md
# Per-Port Lane Reversal and Polarity Mapper

This block steers received 10-bit symbol lanes from the physical lane order of a three-port switch into the logical lane order that each port's link logic expects. Every port owns four physical lanes. For each port the block complements any received lane whose polarity-inversion mask bit is set. It then reorders the lanes, either straight or reversed, and blanks the lanes that the negotiated link width leaves unused.

Each port has a reversal strap input. The strap is sampled into a per-port override bit at reset, and after that the bit changes only through a small write port. The override takes effect only when that port's link-up signal rises. While a link is up, its lane order therefore stays fixed, whatever writes arrive in the meantime. Results are registered, with one clock of latency.

Top module: `lane_rev_mapper`

## Requirements
- R1: While reset is held, every symbol output is zero and every lane disable bit is 1. When reset releases, each port's override bit and active reversal equal that port's strap input as sampled during reset.
- R2: Before reordering, a received symbol is complemented on all 10 bits when the mask bit of its physical lane is 1 (mask bit index = port*4 + physical lane), and passed unchanged when the mask bit is 0.
- R3: A write with `wr_en`=1 sets the override bit of port `wr_port` to `wr_rev` and leaves the other ports' override bits alone. Strap changes after reset have no effect.
- R4: A port's active reversal loads its override bit on the clock after the port's `link_up` goes from 0 to 1. It holds at every other time, including while the link is up and while it is down.
- R5: At x4 width, logical lane i carries physical lane i when not reversed, and physical lane 3-i when reversed.
- R6: Width code 2'b00 is x1 and 2'b01 is x2; 2'b10 and 2'b11 are both x4. At x1 only logical lane 0 is active, and at x2 logical lanes 0 and 1 are active. Each active lane uses the same mapping as at x4, so a reversed x2 port reads physical lanes 3 and 2 and a reversed x1 port reads physical lane 3.
- R7: Each inactive logical lane outputs symbol 0 with its disable bit at 1. Each active lane has its disable bit at 0.
- R8: Outputs change only on a clock edge and reflect the inputs sampled at that edge. A new input does not appear before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_rev | input | 3 | Per-port reversal strap, sampled during reset |
| wr_en | input | 1 | Override write strobe |
| wr_port | input | 2 | Port addressed by the write |
| wr_rev | input | 1 | Override value written |
| link_up | input | 3 | Per-port link-up level; its rising edge latches reversal |
| link_width | input | 6 | Per-port width code, 2 bits per port, port p at [2p+1:2p] |
| pol_mask | input | 12 | Per-physical-lane polarity inversion, bit p*4+lane |
| rx_sym | input | 120 | Physical lane symbols, lane p*4+l at bits [(p*4+l)*10 +: 10] |
| lane_sym | output | 120 | Logical lane symbols, same packing as rx_sym |
| lane_dis | output | 12 | Logical lane disable, bit p*4+l |

## Verification
The datapath is swept over all eight combinations of per-port reversal. Each combination is tried with every width code and with four mask patterns (none, all, alternating and its complement), rotated across ports so that each port sees a different width and mask in the same cycle. Random symbols make any swapped or duplicated lane visible. Reversal versus straight order separates the mappings i and 3-i. The x1 and x2 codes show whether a reversed narrow link reads the top physical lanes and blanks the rest. Separate sequences write the override while a link is up, drop the link without raising it, change the strap after reset, and present new data between edges. Each of these checks whether a change leaks through before it should.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  typedef enum logic [1:0] {
    LW_X1  = 2'd0,
    LW_X2  = 2'd1,
    LW_X4  = 2'd2,
    LW_X4B = 2'd3
  } lw_e;

  // number of logical lanes a width code leaves active
  function automatic int lanes_in_use(logic [1:0] w, int nl);
    case (w)
      LW_X1:   return 1;
      LW_X2:   return (nl < 2) ? nl : 2;
      default: return nl;
    endcase
  endfunction

  // physical lane feeding a logical lane
  function automatic int phys_of(logic rev, int lg, int nl);
    return rev ? (nl - 1 - lg) : lg;
  endfunction

endpackage

// File: rtl/lrm_ctrl.sv
module lrm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic wr_hit,
  input  logic wr_val,
  input  logic link_up,
  output logic act_rev
);

  logic ovr_q;
  logic lu_q;
  logic link_rise;

  assign link_rise = link_up & ~lu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q   <= strap;
      act_rev <= strap;
      lu_q    <= 1'b0;
    end else begin
      lu_q <= link_up;
      if (wr_hit)    ovr_q   <= wr_val;
      if (link_rise) act_rev <= ovr_q;
    end
  end

  // R3: override only moves on a write
  a_r3_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ovr_q));

  // R4: active reversal frozen except after a link-up edge
  a_r4_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rise |=> $stable(act_rev));

  // R4: on the edge, the stored override is taken
  a_r4_act_take: assert property (@(posedge clk) disable iff (!rst_n)
    link_rise |=> act_rev == $past(ovr_q));

endmodule

// File: rtl/lrm_lane_map.sv
module lrm_lane_map
  import lrm_pkg::*;
#(
  parameter int NL   = 4,
  parameter int SW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rev,
  input  logic [1:0]       width,
  input  logic [NL-1:0]    mask,
  input  logic [NL*SW-1:0] rx,
  output logic [NL*SW-1:0] sym,
  output logic [NL-1:0]    dis
);

  localparam int PIW = (NL > 1) ? $clog2(NL) : 1;

  logic [SW-1:0]    corr [NL];
  logic [NL*SW-1:0] sym_nxt;
  logic [NL-1:0]    dis_nxt;
  logic [NL:0]      act_plus1;
  int               nact;

  // polarity correction on physical lanes
  genvar gl;
  generate
    for (gl = 0; gl < NL; gl++) begin : g_pol
      assign corr[gl] = rx[gl*SW +: SW] ^ {SW{mask[gl]}};
    end
  endgenerate

  always_comb begin
    nact    = lanes_in_use(width, NL);
    sym_nxt = '0;
    dis_nxt = '1;
    for (int lg = 0; lg < NL; lg++) begin
      if (lg < nact) begin
        sym_nxt[lg*SW +: SW] = corr[PIW'(phys_of(rev, lg, NL))];
        dis_nxt[lg]          = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym <= '0;
      dis <= '1;
    end else begin
      sym <= sym_nxt;
      dis <= dis_nxt;
    end
  end

  assign act_plus1 = {1'b0, ~dis} + (NL+1)'(1);

  // R6: active lanes always form a run starting at logical lane 0
  a_r6_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_plus1));

  // R7: disabled lanes carry zero
  generate
    for (gl = 0; gl < NL; gl++) begin : g_idle
      a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dis[gl] |-> sym[gl*SW +: SW] == '0);
    end
  endgenerate

  // R2: straight x4, lane 0 is the corrected physical lane 0
  a_r2_lane0_pol: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev && width[1]) |=> sym[SW-1:0] == $past(rx[SW-1:0] ^ {SW{mask[0]}}));

endmodule

// File: rtl/lane_rev_mapper.sv
module lane_rev_mapper #(
  parameter int NPORTS = 3,
  parameter int NLANES = 4,
  parameter int SYMW   = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORTS-1:0]              strap_rev,
  input  logic                           wr_en,
  input  logic [$clog2(NPORTS)-1:0]      wr_port,
  input  logic                           wr_rev,
  input  logic [NPORTS-1:0]              link_up,
  input  logic [NPORTS*2-1:0]            link_width,
  input  logic [NPORTS*NLANES-1:0]       pol_mask,
  input  logic [NPORTS*NLANES*SYMW-1:0]  rx_sym,
  output logic [NPORTS*NLANES*SYMW-1:0]  lane_sym,
  output logic [NPORTS*NLANES-1:0]       lane_dis
);

  localparam int PW  = $clog2(NPORTS);
  localparam int PSW = NLANES * SYMW;

  logic [NPORTS-1:0] act_rev;
  logic [NPORTS-1:0] wr_hit;

  genvar gp;
  generate
    for (gp = 0; gp < NPORTS; gp++) begin : g_port
      assign wr_hit[gp] = wr_en && (wr_port == PW'(gp));

      lrm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap   (strap_rev[gp]),
        .wr_hit  (wr_hit[gp]),
        .wr_val  (wr_rev),
        .link_up (link_up[gp]),
        .act_rev (act_rev[gp])
      );

      lrm_lane_map #(.NL(NLANES), .SW(SYMW)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .rev   (act_rev[gp]),
        .width (link_width[gp*2 +: 2]),
        .mask  (pol_mask[gp*NLANES +: NLANES]),
        .rx    (rx_sym[gp*PSW +: PSW]),
        .sym   (lane_sym[gp*PSW +: PSW]),
        .dis   (lane_dis[gp*NLANES +: NLANES])
      );
    end
  endgenerate

  // R3: a write strobe addresses at most one port
  a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: tb/lane_rev_mapper_test.sv
module lane_rev_mapper_test;

  localparam int NP = 3;
  localparam int NL = 4;
  localparam int SW = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     strap_rev;
  logic              wr_en;
  logic [1:0]        wr_port;
  logic              wr_rev;
  logic [NP-1:0]     link_up;
  logic [NP*2-1:0]   link_width;
  logic [NP*NL-1:0]  pol_mask;
  logic [NP*NL*SW-1:0] rx_sym;
  logic [NP*NL*SW-1:0] lane_sym;
  logic [NP*NL-1:0]    lane_dis;

  int checks = 0;
  int fails  = 0;

  logic [NP-1:0] ovr_m;
  logic [NP-1:0] act_m;
  logic [NP*NL*SW-1:0] exp_sym;
  logic [NP*NL-1:0]    exp_dis;

  always #4 clk = ~clk;

  lane_rev_mapper uut (
    .clk(clk), .rst_n(rst_n), .strap_rev(strap_rev), .wr_en(wr_en),
    .wr_port(wr_port), .wr_rev(wr_rev), .link_up(link_up),
    .link_width(link_width), .pol_mask(pol_mask), .rx_sym(rx_sym),
    .lane_sym(lane_sym), .lane_dis(lane_dis)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  // expected outputs from the current inputs and the bench's reversal model
  task automatic compute_exp();
    exp_sym = '0;
    exp_dis = '1;
    for (int p = 0; p < NP; p++) begin
      int w = int'(link_width[p*2 +: 2]);
      int n = (w >= 2) ? NL : (1 << w);
      for (int l = 0; l < n; l++) begin
        int ph = act_m[p] ? (NL - 1 - l) : l;
        int pi = p*NL + ph;
        exp_sym[(p*NL+l)*SW +: SW] = rx_sym[pi*SW +: SW] ^ (pol_mask[pi] ? 10'h3FF : 10'h000);
        exp_dis[p*NL+l] = 1'b0;
      end
    end
  endtask

  task automatic check_ports(string tag);
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (lane_sym[p*NL*SW +: NL*SW] !== exp_sym[p*NL*SW +: NL*SW] ||
          lane_dis[p*NL +: NL] !== exp_dis[p*NL +: NL]) begin
        fails++;
        $display("FAIL %s port %0d: actual sym=%h dis=%b expected sym=%h dis=%b",
                 tag, p, lane_sym[p*NL*SW +: NL*SW], lane_dis[p*NL +: NL],
                 exp_sym[p*NL*SW +: NL*SW], exp_dis[p*NL +: NL]);
      end
    end
  endtask

  task automatic randomize_rx();
    for (int i = 0; i < NP*NL; i++) rx_sym[i*SW +: SW] = SW'($urandom);
  endtask

  // drive a vector, sample after the edge that captures it
  task automatic apply(logic [NP*2-1:0] w, logic [NP*NL-1:0] m, string tag);
    @(negedge clk);
    link_width = w;
    pol_mask   = m;
    randomize_rx();
    compute_exp();
    @(negedge clk);
    check_ports(tag);
  endtask

  task automatic write_ovr(int p, logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_port = 2'(p); wr_rev = v;
    @(negedge clk);
    wr_en = 1'b0;
    ovr_m[p] = v;
  endtask

  task automatic set_links(logic [NP-1:0] v);
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      if (v[p] && !link_up[p]) act_m[p] = ovr_m[p];
    link_up = v;
  endtask

  initial begin
    logic [NL-1:0] pats [4];
    pats[0] = 4'h0; pats[1] = 4'hF; pats[2] = 4'h5; pats[3] = 4'hA;

    rst_n = 1'b0; strap_rev = 3'b101; wr_en = 1'b0; wr_port = '0; wr_rev = 1'b0;
    link_up = '0; link_width = {NP{2'b10}}; pol_mask = '0; rx_sym = '0;
    randomize_rx();
    repeat (4) @(negedge clk);
    // R1: reset state at the outputs
    exp_sym = '0; exp_dis = '1;
    check_ports("R1 reset");
    rst_n = 1'b1;
    ovr_m = 3'b101; act_m = 3'b101;
    apply({NP{2'b10}}, '0, "R1 strap loaded");

    // R3: strap change after reset is ignored, even across a link-up edge
    strap_rev = 3'b010;
    set_links(3'b111);
    apply({NP{2'b10}}, '0, "R3 strap ignored");

    // sweep: reversal combos x widths x masks (R2 R5 R6 R7)
    for (int rv = 0; rv < 8; rv++) begin
      set_links(3'b000);
      for (int p = 0; p < NP; p++) write_ovr(p, rv[p]);
      set_links(3'b111);
      for (int w = 0; w < 4; w++) begin
        for (int mi = 0; mi < 4; mi++) begin
          logic [NP*2-1:0]  wv;
          logic [NP*NL-1:0] mv;
          for (int p = 0; p < NP; p++) begin
            wv[p*2 +: 2]   = 2'((w + p) % 4);
            mv[p*NL +: NL] = pats[(mi + p) % 4];
          end
          apply(wv, mv, "R2 R5 R6 R7 map");
        end
      end
    end

    // R8: new inputs do not show before the next edge
    apply({NP{2'b10}}, 12'h5A3, "R8 captured");
    @(negedge clk);
    randomize_rx();
    #1;
    check_ports("R8 held between edges");
    compute_exp();
    @(negedge clk);
    check_ports("R8 next edge");

    // R4: write while link up has no effect (act_m is 111 here)
    write_ovr(0, 1'b0);
    apply({NP{2'b10}}, '0, "R4 write while up");
    set_links(3'b110);
    apply({NP{2'b10}}, '0, "R4 link down only");
    set_links(3'b111);
    apply({NP{2'b10}}, '0, "R4 taken on rise");
    // R3: the write to port 0 left ports 1 and 2 reversed
    write_ovr(1, 1'b0);
    set_links(3'b000);
    set_links(3'b111);
    apply({NP{2'b10}}, 12'hC3C, "R3 per-port write");

    summary();
  end

endmodule